// File: doc/BRIEF.md
# Quarter/Half-Rate Digital Quadrature Mixer

This block shifts a complex baseband stream (signed I and Q samples, each marked by a valid strobe) up or down in frequency. It multiplies the stream by a digital local oscillator that runs at either one half or one quarter of the sample rate at its own input. At those two frequencies every oscillator coefficient is 0, +1 or -1. The product therefore reduces to negating a channel, swapping the channels, or zeroing one of them. The block uses no multipliers and no phase accumulator. A two-bit phase counter steps once per accepted sample and chooses the current coefficient pair.

Three fields set the operation. They are loaded through a single-cycle write strobe and take effect from the cycle after the write:
- an oscillator selector: off, half rate or quarter rate;
- a real/complex choice;
- a rotation direction, which picks the image that the complex mixer cancels.

Complex mixing exists only at quarter rate. A complex request at any other rate runs as real mixing. Each output sample is registered, so it appears one clock after its input, together with an output valid.

Top module: `qmix_top`

## Requirements
- R1: After reset, out_valid is 0 and out_i and out_q are 0. The configuration comes up as quarter-rate LO (selector 2'b10), real mixing (cfg_real=1) and rotation direction 0.
- R2: out_valid is high exactly one cycle after each cycle with in_valid high and low otherwise. While no sample is accepted, out_i and out_q hold their last value, whatever is on in_i and in_q.
- R3: With selector 2'b00, each output equals its input sample unchanged, on both channels.
- R4: With selector 2'b01, both channels are multiplied by +1, -1, +1, -1 … over successive samples, starting with +1 at phase 0. This holds whatever the value of cfg_real.
- R5: With selector 2'b10 or 2'b11 and cfg_real=1, I is multiplied by 1, 0, -1, 0 and Q by 0, 1, 0, -1 over phases 0 to 3. The rotation bit has no effect in real mode.
- R6: With selector 2'b10 or 2'b11, cfg_real=0 and cfg_sign=0, phases 0 to 3 produce (I,Q), (Q,-I), (-I,-Q) and (-Q,I). This is rotation by e^-jπn/2.
- R7: With selector 2'b10 or 2'b11, cfg_real=0 and cfg_sign=1, phases 0 to 3 produce (I,Q), (-Q,I), (-I,-Q) and (Q,-I). This is rotation by e^+jπn/2.
- R8: The phase advances by one (modulo 4) only on a cycle with in_valid high. Idle cycles leave it unchanged.
- R9: A configuration write that changes the selector value (including between 2'b10 and 2'b11) returns the phase to 0. A write that keeps the selector leaves the phase unchanged.
- R10: Negating the most negative sample value (-2^(W-1)) gives the most positive value (2^(W-1)-1) and does not wrap.
- R11: cfg_wr loads cfg_mode, cfg_real and cfg_sign on the clock edge. Samples presented in later cycles use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads the three configuration fields |
| cfg_mode | input | 2 | LO selector: 00 off, 01 half rate, 10/11 quarter rate |
| cfg_real | input | 1 | 1 = real mixing, 0 = complex (image-reject) request |
| cfg_sign | input | 1 | Complex rotation direction: 0 = e^-j, 1 = e^+j |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | Signed in-phase sample |
| in_q | input | W | Signed quadrature sample |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | W | Signed mixed in-phase output |
| out_q | output | W | Signed mixed quadrature output |

## Verification
The embedded properties check on every cycle:
- that the output strobe follows the input strobe and that the outputs hold between samples;
- that the phase steps, holds and clears as stated;
- that configuration writes are captured;
- pass-through with the oscillator off, and the saturating result for the most negative value at half rate.

Only the directed scenarios can show the full quarter-rate coefficient sequences in both rotation directions. They also show the fall-back from complex to real at half rate, that the rotation bit has no effect in real mode, and that the phase stays in step across idle gaps and mode changes.

// File: rtl/qmix_pkg.sv
`timescale 1ns/1ps
package qmix_pkg;
  typedef enum logic [1:0] {
    LO_NONE    = 2'd0,
    LO_HALF    = 2'd1,
    LO_QUARTER = 2'd2
  } lo_e;

  localparam logic [1:0] MODE_RST = 2'b10;
  localparam logic       REAL_RST = 1'b1;
  localparam logic       SIGN_RST = 1'b0;

  function automatic lo_e decode_lo(input logic [1:0] mode);
    case (mode)
      2'b00:   return LO_NONE;
      2'b01:   return LO_HALF;
      default: return LO_QUARTER;
    endcase
  endfunction
endpackage

// File: rtl/qmix_cfg_reg.sv
`timescale 1ns/1ps
module qmix_cfg_reg
  import qmix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_real,
  input  logic       cfg_sign,
  output lo_e        lo_sel,
  output logic       eff_complex,
  output logic       rot_pos,
  output logic       mode_clr
);
  logic [1:0] mode_q;
  logic       real_q;
  logic       sign_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      real_q <= REAL_RST;
      sign_q <= SIGN_RST;
    end else if (cfg_wr) begin
      mode_q <= cfg_mode;
      real_q <= cfg_real;
      sign_q <= cfg_sign;
    end
  end

  assign lo_sel      = decode_lo(mode_q);
  assign eff_complex = !real_q && (lo_sel == LO_QUARTER);
  assign rot_pos     = sign_q;
  assign mode_clr    = cfg_wr && (cfg_mode != mode_q);

  // R11
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (mode_q == $past(cfg_mode)) && (real_q == $past(cfg_real))
               && (sign_q == $past(cfg_sign)));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(mode_q) && $stable(real_q) && $stable(sign_q));
endmodule

// File: rtl/qmix_phase.sv
`timescale 1ns/1ps
module qmix_phase #(
  parameter int N_PHASE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       advance,
  input  logic                       clear,
  output logic [$clog2(N_PHASE)-1:0] phase
);
  localparam int PH_W = $clog2(N_PHASE);
  localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (clear)   phase_q <= '0;
    else if (advance) phase_q <= phase_q + PH_ONE;
  end

  assign phase = phase_q;

  // R8
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> phase_q == $past(phase_q) + PH_ONE);

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear) |=> $stable(phase_q));

  // R9
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> phase_q == '0);
endmodule

// File: rtl/qmix_rotator.sv
`timescale 1ns/1ps
module qmix_rotator
  import qmix_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  input  lo_e                 lo_sel,
  input  logic                eff_complex,
  input  logic                rot_pos,
  input  logic [1:0]          phase,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  function automatic logic signed [W-1:0] sat_neg(input logic signed [W-1:0] x);
    if (x == MINV) return MAXV;
    return -x;
  endfunction

  logic signed [W-1:0] mix_i, mix_q;
  logic signed [W-1:0] neg_i, neg_q;

  assign neg_i = sat_neg(in_i);
  assign neg_q = sat_neg(in_q);

  always_comb begin
    mix_i = in_i;
    mix_q = in_q;
    case (lo_sel)
      LO_HALF: begin
        if (phase[0]) begin
          mix_i = neg_i;
          mix_q = neg_q;
        end
      end
      LO_QUARTER: begin
        if (eff_complex) begin
          case (phase)
            2'd0: begin mix_i = in_i;  mix_q = in_q;  end
            2'd1: begin
              mix_i = rot_pos ? neg_q : in_q;
              mix_q = rot_pos ? in_i  : neg_i;
            end
            2'd2: begin mix_i = neg_i; mix_q = neg_q; end
            default: begin
              mix_i = rot_pos ? in_q  : neg_q;
              mix_q = rot_pos ? neg_i : in_i;
            end
          endcase
        end else begin
          case (phase)
            2'd0:    begin mix_i = in_i;  mix_q = '0;    end
            2'd1:    begin mix_i = '0;    mix_q = in_q;  end
            2'd2:    begin mix_i = neg_i; mix_q = '0;    end
            default: begin mix_i = '0;    mix_q = neg_q; end
          endcase
        end
      end
      default: begin
        mix_i = in_i;
        mix_q = in_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= mix_i;
        out_q <= mix_q;
      end
    end
  end

  // R2
  out_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  out_valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_i) && $stable(out_q));

  // R3
  passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lo_sel == LO_NONE) |=> (out_i == $past(in_i)) && (out_q == $past(in_q)));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lo_sel == LO_HALF && phase[0] && in_i == MINV) |=> out_i == MAXV);
endmodule

// File: rtl/qmix_top.sv
`timescale 1ns/1ps
module qmix_top
  import qmix_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_real,
  input  logic                cfg_sign,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  localparam int N_PHASE = 4;

  lo_e        lo_sel;
  logic       eff_complex;
  logic       rot_pos;
  logic       mode_clr;
  logic [1:0] phase;

  qmix_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_mode   (cfg_mode),
    .cfg_real   (cfg_real),
    .cfg_sign   (cfg_sign),
    .lo_sel     (lo_sel),
    .eff_complex(eff_complex),
    .rot_pos    (rot_pos),
    .mode_clr   (mode_clr)
  );

  qmix_phase #(.N_PHASE(N_PHASE)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(in_valid),
    .clear  (mode_clr),
    .phase  (phase)
  );

  qmix_rotator #(.W(W)) u_rot (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_i       (in_i),
    .in_q       (in_q),
    .lo_sel     (lo_sel),
    .eff_complex(eff_complex),
    .rot_pos    (rot_pos),
    .phase      (phase),
    .out_valid  (out_valid),
    .out_i      (out_i),
    .out_q      (out_q)
  );
endmodule

// File: tb/qmix_top_bench.sv
`timescale 1ns/1ps
module qmix_top_bench;
  localparam int W    = 16;
  localparam int MAXI = (1 <<< (W-1)) - 1;
  localparam int MINI = -(1 <<< (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_real = 1'b0;
  logic cfg_sign = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_i = '0;
  logic signed [W-1:0] in_q = '0;
  logic out_valid;
  logic signed [W-1:0] out_i;
  logic signed [W-1:0] out_q;

  always #5 clk = ~clk;

  qmix_top #(.W(W)) u_qmix_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_real(cfg_real), .cfg_sign(cfg_sign), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_mode = 2, m_real = 1, m_sign = 0, m_phase = 0;
  int last_i = 0, last_q = 0;

  function automatic int clampv(input int v);
    if (v > MAXI) return MAXI;
    if (v < MINI) return MINI;
    return v;
  endfunction

  function automatic void model(input int i, input int q, output int ei, output int eq);
    int cosv, sinv, s;
    cosv = (m_phase == 0) ? 1 : (m_phase == 2) ? -1 : 0;
    sinv = (m_phase == 1) ? 1 : (m_phase == 3) ? -1 : 0;
    if (m_mode == 0) begin
      ei = i; eq = q;
    end else if (m_mode == 1) begin
      s = (m_phase % 2 == 1) ? -1 : 1;
      ei = i * s; eq = q * s;
    end else if (m_real == 0) begin
      s = m_sign ? sinv : -sinv;
      ei = i * cosv - q * s;
      eq = i * s + q * cosv;
    end else begin
      ei = i * cosv; eq = q * sinv;
    end
    ei = clampv(ei); eq = clampv(eq);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int mode, input int rl, input int sg);
    in_valid = 1'b0;
    cfg_wr = 1'b1; cfg_mode = 2'(mode); cfg_real = rl[0]; cfg_sign = sg[0];
    @(negedge clk);
    cfg_wr = 1'b0;
    if (mode != m_mode) m_phase = 0;
    m_mode = mode; m_real = rl; m_sign = sg;
  endtask

  task automatic send(input int i, input int q, input string req);
    int ei, eq;
    model(i, q, ei, eq);
    in_valid = 1'b1; in_i = W'(i); in_q = W'(q);
    @(negedge clk);
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "out_i", int'(out_i), ei);
    check(req, "out_q", int'(out_q), eq);
    m_phase = (m_phase + 1) % 4;
    last_i = ei; last_q = eq;
  endtask

  task automatic idle(input int n, input string req);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      in_i = W'(1234 + k); in_q = W'(-777 - k);
      @(negedge clk);
      check(req, "out_valid idle", int'(out_valid), 0);
      check(req, "out_i hold", int'(out_i), last_i);
      check(req, "out_q hold", int'(out_q), last_q);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "out_valid reset", int'(out_valid), 0);
    check("R1", "out_i reset", int'(out_i), 0);
    check("R1", "out_q reset", int'(out_q), 0);
    rst_n = 1'b1;
    m_mode = 2; m_real = 1; m_sign = 0; m_phase = 0; last_i = 0; last_q = 0;
  endtask

  task automatic t_defaults();
    for (int k = 0; k < 4; k++) send(1000 + k, 2000 - k, "R1 default quarter real");
    idle(1, "R2");
  endtask

  task automatic t_off();
    cfg_write(0, 0, 1);
    send(100, -200, "R3");
    send(MINI, MAXI, "R3");
    send(-5, 7, "R3");
    idle(2, "R2");
  endtask

  task automatic t_half();
    cfg_write(1, 1, 0);
    for (int k = 0; k < 4; k++) send(300 + k, -400 + k, "R4 half real");
    cfg_write(1, 0, 1);
    for (int k = 0; k < 4; k++) send(-50 - k, 60 + k, "R4 half complex request");
    idle(1, "R2");
  endtask

  task automatic t_quarter_real();
    cfg_write(2, 1, 1);
    for (int k = 0; k < 4; k++) send(700 + k, 900 - k, "R5 sign ignored");
    cfg_write(3, 1, 0);
    for (int k = 0; k < 4; k++) send(-31 * k, 17 + k, "R5 mode 11");
    idle(1, "R2");
  endtask

  task automatic t_complex_neg();
    cfg_write(2, 0, 0);
    for (int k = 0; k < 5; k++) send(1000 + 3 * k, -2000 + k, "R6");
    idle(1, "R2");
  endtask

  task automatic t_complex_pos();
    cfg_write(3, 0, 1);
    for (int k = 0; k < 5; k++) send(-123 + k, 456 - k, "R7");
    idle(1, "R2");
  endtask

  task automatic t_gaps();
    cfg_write(2, 0, 0);
    send(11, 22, "R8 before gap");
    idle(3, "R8 gap");
    send(33, 44, "R8 after gap");
    idle(2, "R8 gap");
    send(55, 66, "R8 after gap");
    send(77, 88, "R8 wrap");
    send(99, 111, "R8 wrap");
  endtask

  task automatic t_phase_clear();
    cfg_write(2, 0, 0);
    send(10, 20, "R9 setup");
    send(30, 40, "R9 setup");
    cfg_write(2, 0, 1);
    send(50, 60, "R9 same selector keeps phase");
    cfg_write(3, 0, 1);
    send(70, 80, "R9 changed selector clears phase");
    send(90, 100, "R9 after clear");
    cfg_write(3, 0, 0);
    send(5, 6, "R11 new sign used at once");
  endtask

  task automatic t_saturate();
    cfg_write(1, 1, 0);
    send(MINI, MINI, "R10 half phase0");
    send(MINI, MINI, "R10 half phase1");
    cfg_write(2, 0, 0);
    for (int k = 0; k < 4; k++) send(MINI, MINI, "R10 quarter complex");
    cfg_write(2, 1, 0);
    for (int k = 0; k < 4; k++) send(MINI, MINI, "R10 quarter real");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_defaults();
    t_off();
    t_half();
    t_quarter_real();
    t_complex_neg();
    t_complex_pos();
    t_gaps();
    t_phase_clear();
    t_saturate();
    idle(1, "R2 end");
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule